// File: doc/BRIEF.md
# RTC Clock Calibration Unit

This block sits between a raw real-time-clock tick source and the timekeeping logic that consumes it. The raw clock is presented as a single-cycle enable `tick_i` in the system clock domain. The block slows the tick stream by a programmable number of parts per million. In every window of 2^WIN_BITS input ticks (2^20 by default), it removes exactly as many ticks as the programmed calibration value. The removals are spaced evenly across the window by an accumulator, so they never arrive as one burst. One removal per 2^20-tick window slows the clock by about 0.954 ppm, and the 7-bit value reaches about 121 ppm.

The block also owns one shared output pin. Software can route one of three things to it: a divide-by-64 copy of the undisturbed raw tick stream, the alarm event, or the once-per-second event. The divided clock is taken before any tick is removed, so it can be measured against a reference with a steady period. Whenever the pin is driven, the block raises a blocking signal, because the same pin cannot also serve as a tamper input.

Configuration arrives on a single write port. The event routing fields sit in the battery-backed domain. They survive a main-supply reset, which clears only the calibration value and the calibration-output bit.

Top module: `rtc_cal_unit`

## Requirements
- R1: After both resets, the pin output, pin drive enable and tamper block are 0. Every input tick passes to `tick_o`.
- R2: `tick_o` is never 1 in a cycle where `tick_i` is 0.
- R3: In each window of 2^WIN_BITS input ticks, counted from reset, exactly as many ticks are removed as the calibration value active for that window.
- R4: Let k be the 0-based tick index within the window and c the active value. The tick at index k is removed iff floor((k+1)*c/2^WIN_BITS) > floor(k*c/2^WIN_BITS).
- R5: A newly written calibration value takes effect only from the first tick of the next window. The window in progress keeps its old value.
- R6: With a calibration value of 0, no tick is ever removed.
- R7: With the calibration-output bit set, `pin_o` follows a counter of all input ticks, dropped ones included. After reset it is 0 for the first 32 ticks and 1 for the next 32, repeating every 64 ticks.
- R8: When the calibration-output bit and the event-enable bit are both set, the pin carries the divided clock, not the event.
- R9: With the event-enable bit set and the calibration-output bit clear, `pin_o` equals `alarm_i` when the select bit is 0 and `second_i` when it is 1.
- R10: `pin_oe_o` and `tamper_block_o` are 1 exactly when the calibration-output bit or the event-enable bit is set. `pin_o` is 0 when neither is set.
- R11: `rst_ni` clears the calibration value and the calibration-output bit but leaves the event-enable and select bits intact. Only `bat_rst_ni` clears those two.
- R12: A write with `wr_en_i` high loads all fields at the clock edge. The layout is: `wr_data_i[0]` select, `[1]` event enable, `[2]` calibration output, `[9:3]` calibration value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Main-supply reset, active low, asynchronous |
| bat_rst_ni | input | 1 | Battery-domain reset, active low, asynchronous |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 10 | Configuration write data |
| tick_i | input | 1 | Raw RTC clock enable, one cycle per tick |
| alarm_i | input | 1 | Alarm event |
| second_i | input | 1 | Once-per-second event |
| tick_o | output | 1 | Calibrated tick enable |
| pin_o | output | 1 | Shared pin output value |
| pin_oe_o | output | 1 | Shared pin drive enable |
| tamper_block_o | output | 1 | Tamper input must be ignored |

## Verification
A wrong window position or a wrong accumulator value changes which tick indices are removed. Because `tick_o` is compared with a reference on every cycle, such a fault shows at the first mis-timed removal, which is at most about 2^WIN_BITS/c ticks after the fault. A miscounted window or a calibration value latched too early shows as a wrong per-window removal count at the next window boundary. A corrupted divider or mux state appears on `pin_o` within one half-period of the divided clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_W = 7;
  localparam int WR_W  = CAL_W + 3;

  // packed layout equals wr_data_i: cal in [WR_W-1:3], flags in [2:0]
  typedef struct packed {
    logic [CAL_W-1:0] cal;
    logic             cal_out;
    logic             evt_en;
    logic             evt_sel;
  } cfg_t;
endpackage

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bat_rst_ni,
  input  logic wr_en_i,
  input  cfg_t wr_cfg_i,
  output cfg_t cfg_o
);
  logic [CAL_W-1:0] cal_q;
  logic             cal_out_q;
  logic             evt_en_q;
  logic             evt_sel_q;

  // main-supply domain fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q     <= '0;
      cal_out_q <= 1'b0;
    end else if (wr_en_i) begin
      cal_q     <= wr_cfg_i.cal;
      cal_out_q <= wr_cfg_i.cal_out;
    end
  end

  // battery domain fields
  always_ff @(posedge clk_i or negedge bat_rst_ni) begin
    if (!bat_rst_ni) begin
      evt_en_q  <= 1'b0;
      evt_sel_q <= 1'b0;
    end else if (wr_en_i) begin
      evt_en_q  <= wr_cfg_i.evt_en;
      evt_sel_q <= wr_cfg_i.evt_sel;
    end
  end

  assign cfg_o = '{cal: cal_q, cal_out: cal_out_q, evt_en: evt_en_q, evt_sel: evt_sel_q};
endmodule

// File: rtl/rtc_cal_skipper.sv
module rtc_cal_skipper #(
  parameter int WIN_BITS = 20,
  parameter int CAL_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CAL_W-1:0] cal_i,
  output logic             tick_o,
  output logic             win_wrap_o,
  output logic [CAL_W-1:0] cal_act_o
);
  logic [WIN_BITS-1:0] win_cnt;
  logic [WIN_BITS-1:0] acc;
  logic [CAL_W-1:0]    cal_act;
  logic [WIN_BITS:0]   sum;
  logic                win_last;
  logic                drop;

  // carry out of acc + cal marks an evenly spread removal
  assign sum        = {1'b0, acc} + (WIN_BITS+1)'(cal_act);
  assign drop       = tick_i & sum[WIN_BITS];
  assign win_last   = &win_cnt;
  assign win_wrap_o = tick_i & win_last;
  assign tick_o     = tick_i & ~drop;
  assign cal_act_o  = cal_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      acc     <= '0;
      cal_act <= '0;
    end else if (tick_i) begin
      win_cnt <= win_cnt + 1'b1;
      if (win_last) begin
        acc     <= '0;
        cal_act <= cal_i;
      end else begin
        acc <= sum[WIN_BITS-1:0];
      end
    end
  end
endmodule

// File: rtl/rtc_cal_div.sv
module rtc_cal_div #(
  parameter int DIV_BITS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic div_clk_o
);
  logic [DIV_BITS-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (tick_i) cnt <= cnt + 1'b1;
  end

  assign div_clk_o = cnt[DIV_BITS-1];
endmodule

// File: rtl/rtc_cal_pinmux.sv
module rtc_cal_pinmux (
  input  logic cal_out_i,
  input  logic evt_en_i,
  input  logic evt_sel_i,
  input  logic div_clk_i,
  input  logic alarm_i,
  input  logic second_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic tamper_block_o
);
  logic evt;

  assign evt = evt_sel_i ? second_i : alarm_i;

  always_comb begin
    if (cal_out_i)     pin_o = div_clk_i;
    else if (evt_en_i) pin_o = evt;
    else               pin_o = 1'b0;
  end

  assign pin_oe_o       = cal_out_i | evt_en_i;
  assign tamper_block_o = cal_out_i | evt_en_i;
endmodule

// File: rtl/rtc_cal_unit.sv
module rtc_cal_unit
  import rtc_cal_pkg::*;
#(
  parameter int WIN_BITS = 20,
  parameter int DIV_BITS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bat_rst_ni,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            tick_i,
  input  logic            alarm_i,
  input  logic            second_i,
  output logic            tick_o,
  output logic            pin_o,
  output logic            pin_oe_o,
  output logic            tamper_block_o
);
  cfg_t             cfg;
  logic [CAL_W-1:0] cal_act;
  logic             win_wrap;
  logic             div_clk;

  rtc_cal_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bat_rst_ni (bat_rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_cfg_i   (cfg_t'(wr_data_i)),
    .cfg_o      (cfg)
  );

  rtc_cal_skipper #(.WIN_BITS(WIN_BITS), .CAL_W(CAL_W)) u_skip (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cal_i      (cfg.cal),
    .tick_o     (tick_o),
    .win_wrap_o (win_wrap),
    .cal_act_o  (cal_act)
  );

  rtc_cal_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .div_clk_o (div_clk)
  );

  rtc_cal_pinmux u_mux (
    .cal_out_i      (cfg.cal_out),
    .evt_en_i       (cfg.evt_en),
    .evt_sel_i      (cfg.evt_sel),
    .div_clk_i      (div_clk),
    .alarm_i        (alarm_i),
    .second_i       (second_i),
    .pin_o          (pin_o),
    .pin_oe_o       (pin_oe_o),
    .tamper_block_o (tamper_block_o)
  );
endmodule

// File: rtl/rtc_cal_unit_chk.sv
module rtc_cal_unit_chk
  import rtc_cal_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             tick_o,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic [CAL_W-1:0] cal_act,
  input logic             win_wrap,
  input logic             div_clk
);
  assert_no_phantom_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !tick_o);

  assert_zero_cal_passes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_act == '0 && tick_i) |-> tick_o);

  assert_cal_held_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(win_wrap) |-> $stable(cal_act));

  assert_div_moves_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(div_clk));

  assert_quiet_pin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);
endmodule

bind rtc_cal_unit rtc_cal_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .tick_o   (tick_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .cal_act  (cal_act),
  .win_wrap (win_wrap),
  .div_clk  (div_clk)
);

// File: tb/tb_rtc_cal_unit.sv
module tb_rtc_cal_unit;
  localparam int WB  = 10;
  localparam int W   = 1 << WB;
  localparam int DB  = 6;
  localparam int DIV = 1 << DB;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bat_rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [9:0] wr_data_i = '0;
  logic       tick_i = 1'b0;
  logic       alarm_i = 1'b0;
  logic       second_i = 1'b0;
  logic       tick_o, pin_o, pin_oe_o, tamper_block_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int mcal = 0, mact = 0, mk = 0, mdiv = 0, obs = 0;
  bit mco = 0, men = 0, msel = 0, r5_watch = 0;

  rtc_cal_unit #(.WIN_BITS(WB), .DIV_BITS(DB)) dut (
    .clk_i, .rst_ni, .bat_rst_ni, .wr_en_i, .wr_data_i, .tick_i,
    .alarm_i, .second_i, .tick_o, .pin_o, .pin_oe_o, .tamper_block_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] cfg(input int cal, input bit co, input bit en, input bit sel);
    logic [6:0] c = cal[6:0];
    return {c, co, en, sel};
  endfunction

  task automatic cycle(input logic tk, input logic al, input logic se,
                       input logic we, input logic [9:0] wd);
    logic e_drop, e_pin, e_oe;
    string pr, lab;
    @(negedge clk_i);
    tick_i = tk; alarm_i = al; second_i = se; wr_en_i = we; wr_data_i = wd;
    #1;
    e_drop = tk && ((((mk + 1) * mact) / W) != ((mk * mact) / W));
    e_oe   = mco || men;
    if (mco) begin e_pin = (mdiv >= DIV/2); pr = men ? "R8" : "R7"; end
    else if (men) begin e_pin = msel ? se : al; pr = "R9"; end
    else begin e_pin = 1'b0; pr = "R10"; end
    chk(tk ? "R4" : "R2", tick_o, tk && !e_drop);
    chk(pr, pin_o, e_pin);
    chk("R10", pin_oe_o, e_oe);
    chk("R10", tamper_block_o, e_oe);
    if (tk && !tick_o) obs++;
    @(posedge clk_i);
    if (tk) begin
      if (mk == W - 1) begin
        lab = (mact == 0) ? "R6" : "R3";
        if (r5_watch) begin lab = "R5"; r5_watch = 0; end
        chk_int(lab, obs, mact);
        obs = 0; mk = 0; mact = mcal;
      end else mk++;
      mdiv = (mdiv + 1) % DIV;
    end
    if (we) begin
      msel = wd[0]; men = wd[1]; mco = wd[2]; mcal = int'(wd[9:3]);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++)
      cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'b0, '0);
  endtask

  task automatic write(input logic [9:0] wd);
    cycle(1'($urandom_range(0, 1)), 1'b0, 1'b0, 1'b1, wd);
  endtask

  task automatic main_reset(input bit with_bat);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0; alarm_i = 0; second_i = 0;
    rst_ni = 0;
    if (with_bat) bat_rst_ni = 0;
    #1;
    mcal = 0; mact = 0; mk = 0; mdiv = 0; obs = 0; mco = 0;
    if (with_bat) begin men = 0; msel = 0; end
    repeat (2) @(negedge clk_i);
    rst_ni = 1; bat_rst_ni = 1;
  endtask

  initial begin
    #(20 * 190000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
    $finish;
  end

  initial begin
    main_reset(1);
    #2;
    // R1 reset state
    chk("R1", pin_o, 1'b0);
    chk("R1", pin_oe_o, 1'b0);
    chk("R1", tamper_block_o, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, 1'b0, '0);
    chk("R1", tick_o, 1'b1);

    run(2500);                  // R6: zero value, window boundary crossed
    run(300);
    write(cfg(5, 0, 0, 0));     // R12 layout; R5: mid-window write
    r5_watch = 1;
    run(4500);
    write(cfg(127, 0, 0, 0));   // full-scale R3 R4
    run(4500);
    write(cfg(1, 0, 0, 0));
    run(2500);
    write(cfg(1, 1, 0, 0));     // R7 divided clock
    run(400);
    write(cfg(1, 0, 1, 0));     // R9 alarm
    run(100);
    write(cfg(1, 0, 1, 1));     // R9 second
    run(100);
    write(cfg(1, 1, 1, 1));     // R8 priority
    run(150);
    write(cfg(1, 0, 0, 1));     // R10 idle pin
    run(60);
    write(cfg(9, 1, 1, 1));
    run(10);
    main_reset(0);              // R11: event fields survive
    #2;
    chk("R11", pin_oe_o, 1'b1);
    chk("R11", tamper_block_o, 1'b1);
    run(80);
    main_reset(1);
    #2;
    chk("R11", pin_oe_o, 1'b0);
    run(40);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
    $finish;
  end
endmodule